// File: doc/BRIEF.md
# Pipelined Write-Back Cache Controller

This block is a direct-mapped, write-back cache that sits between a processor request port and a main-memory port. Every line keeps a three-valued state (Invalid, Clean, Dirty), the full address it holds and one data word. Requests go through two pipeline stages. The first stage reads the line selected by the low address bits and decides hit or miss. The second stage runs the eviction logic, writes the line and issues any memory message. A store always finishes in the cache. When a store misses on a dirty line, the old line is written back and the new line is installed in the same pass through the pipeline. A store miss does not fetch the line from memory. A load miss writes back a dirty victim, sends a fetch request and waits for the memory response to fill the line.

The four message channels use valid/ready handshakes. A transfer happens on a rising edge where both valid and ready are high. A sender holds valid and the payload steady until that edge. The processor request port drops ready when the first stage is occupied and cannot move on. It also drops ready while a fill is outstanding, and it stays low until the filled word has been delivered on the response channel. The memory request channel stalls the second stage, and through it the first stage, when it is not ready. The response channel holds its word until the processor takes it.

Top module: `wb_cache_ctrl`

## Requirements
- R1: Reset makes every line Invalid and empties both stages and the response register, so cpu_rsp_valid and mem_req_valid are 0 and cpu_req_ready is 1.
- R2: A store whose address matches a non-Invalid line writes the data into that line and makes it Dirty. It sends no memory message, and a later load of that address returns the stored word.
- R3: A load hit returns the line's word on the response channel two clock cycles after the request is accepted, with no memory message.
- R4: A store that misses on an Invalid or Clean line installs its address and data as a Dirty line without sending any memory message, and never sends a fetch request.
- R5: A store that misses on a Dirty line holding another address sends exactly one write-back (mem_req_writeback=1) carrying the old address and data. The line then holds the new address and data as Dirty.
- R6: A load that misses on an Invalid line sends one fetch request (mem_req_writeback=0) carrying the index (address bits [IDX_W-1:0]) and the full requested address. From the cycle after that request is taken, cpu_req_ready stays 0 and no further memory request is issued until the fill word has been returned.
- R7: A load that misses on a Dirty line first writes back the victim's address and data, and then sends the fetch request.
- R8: A load that misses on a Clean line sends no write-back, only the fetch request.
- R9: A taken memory response writes its address and data into the indexed line as Clean and puts its data on the response channel on the next cycle. A later load of that address hits, and a later store miss to that line causes no write-back.
- R10: Two stores presented on consecutive cycles are both accepted with cpu_req_ready high. When they share an index, the second sees the first's line, so the first line is written back.
- R11: Under back-pressure a pending memory request and a pending processor response keep valid high and their payload unchanged until taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can take a request |
| cpu_req_store | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | ADDR_W | Request address |
| cpu_req_wdata | input | DATA_W | Store data |
| cpu_rsp_valid | output | 1 | Load data present |
| cpu_rsp_ready | input | 1 | Processor takes load data |
| cpu_rsp_rdata | output | DATA_W | Load data |
| mem_req_valid | output | 1 | Memory message present |
| mem_req_ready | input | 1 | Memory takes the message |
| mem_req_writeback | output | 1 | 1 = write-back, 0 = fetch request |
| mem_req_idx | output | IDX_W | Line index |
| mem_req_addr | output | ADDR_W | Victim address (write-back) or requested address (fetch) |
| mem_req_wdata | output | DATA_W | Victim data for write-back, zero for fetch |
| mem_rsp_valid | input | 1 | Fill response present |
| mem_rsp_ready | output | 1 | Cache takes the fill |
| mem_rsp_idx | input | IDX_W | Line to fill |
| mem_rsp_addr | input | ADDR_W | Address of the filled line |
| mem_rsp_rdata | input | DATA_W | Fill data |

## Verification
The main function is driven with a sequence of loads and stores. The sequence puts each victim state (Invalid, Clean, Dirty) under both operations. It separates matching from non-matching addresses at one index, and it separates a clean victim from a dirty one through the presence or absence of a write-back. Fill data is derived from the address. This exposes a fill written to the wrong line, and a load hit that returns stale data. Two stores to one index on consecutive cycles test whether the first stage sees the second stage's pending line. Holding memory ready low on a dirty eviction shows whether the write-back payload stays steady and whether the line is replaced too early.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
  typedef enum logic [1:0] {
    LS_INVALID = 2'd0,
    LS_CLEAN   = 2'd1,
    LS_DIRTY   = 2'd2
  } line_state_e;
endpackage

// File: rtl/wbc_line_store.sv
module wbc_line_store
  import wbc_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_state_e       wr_state,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output line_state_e       rd_state,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  line_state_e       state_q [LINES];
  logic [ADDR_W-1:0] addr_q  [LINES];
  logic [DATA_W-1:0] data_q  [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) begin
        state_q[i] <= LS_INVALID;
        addr_q[i]  <= '0;
        data_q[i]  <= '0;
      end
    end else if (wr_en) begin
      state_q[wr_idx] <= wr_state;
      addr_q[wr_idx]  <= wr_addr;
      data_q[wr_idx]  <= wr_data;
    end
  end

  assign rd_state = state_q[rd_idx];
  assign rd_addr  = addr_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/wbc_lookup.sv
module wbc_lookup
  import wbc_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic [ADDR_W-1:0] req_addr,
  input  line_state_e       arr_state,
  input  logic [ADDR_W-1:0] arr_addr,
  input  logic [DATA_W-1:0] arr_data,
  input  logic              fwd_en,
  input  logic [IDX_W-1:0]  fwd_idx,
  input  line_state_e       fwd_state,
  input  logic [ADDR_W-1:0] fwd_addr,
  input  logic [DATA_W-1:0] fwd_data,
  output logic              hit,
  output line_state_e       vic_state,
  output logic [ADDR_W-1:0] vic_addr,
  output logic [DATA_W-1:0] vic_data
);
  logic use_fwd;

  // The line being written by stage two this cycle is newer than the array copy.
  assign use_fwd = fwd_en && (fwd_idx == req_addr[IDX_W-1:0]);

  always_comb begin
    if (use_fwd) begin
      vic_state = fwd_state;
      vic_addr  = fwd_addr;
      vic_data  = fwd_data;
    end else begin
      vic_state = arr_state;
      vic_addr  = arr_addr;
      vic_data  = arr_data;
    end
    hit = (vic_state != LS_INVALID) && (vic_addr == req_addr);
  end
endmodule

// File: rtl/wbc_stage2_ctrl.sv
module wbc_stage2_ctrl
  import wbc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s2_valid,
  input  logic        s2_store,
  input  logic        s2_hit,
  input  line_state_e s2_vic_state,
  input  logic        s2_wb_done,
  input  logic        mreq_ready,
  input  logic        rsp_free,
  output logic        mreq_valid,
  output logic        mreq_wb,
  output logic        done,
  output logic        fill_start,
  output logic        wb_fire,
  output logic        rsp_load,
  output logic        line_we
);
  logic wb_needed;
  logic get_needed;
  logic load_hit;

  assign wb_needed  = s2_valid && !s2_hit && (s2_vic_state == LS_DIRTY) && !s2_wb_done;
  assign get_needed = s2_valid && !s2_store && !s2_hit;
  assign load_hit   = s2_valid && !s2_store && s2_hit;

  assign mreq_valid = wb_needed || get_needed;
  assign mreq_wb    = wb_needed;
  assign wb_fire    = wb_needed && mreq_ready;
  assign rsp_load   = load_hit && rsp_free;

  always_comb begin
    done = 1'b0;
    if (s2_valid) begin
      if (s2_store)      done = !wb_needed || mreq_ready;
      else if (s2_hit)   done = rsp_free;
      else               done = !wb_needed && mreq_ready;
    end
  end

  assign fill_start = done && !s2_store && !s2_hit;
  assign line_we    = done && !load_hit;

  AST_STORE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (s2_valid && s2_store) |-> !(mreq_valid && !mreq_wb)); // R4
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import wbc_pkg::*;
#(
  parameter int LINES  = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_store,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  input  logic              cpu_rsp_ready,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_writeback,
  output logic [IDX_W-1:0]  mem_req_idx,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [IDX_W-1:0]  mem_rsp_idx,
  input  logic [ADDR_W-1:0] mem_rsp_addr,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  // stage one: captured request
  logic              s1_v;
  logic              s1_store;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_data;
  // stage two: request plus lookup result
  logic              s2_v;
  logic              s2_store;
  logic [ADDR_W-1:0] s2_addr;
  logic [DATA_W-1:0] s2_data;
  logic              s2_hit;
  line_state_e       s2_vstate;
  logic [ADDR_W-1:0] s2_vaddr;
  logic [DATA_W-1:0] s2_vdata;
  logic              s2_wb_done;
  // miss and response tracking
  logic              fill_wait;
  logic              rsp_v;
  logic              rsp_fill;
  logic [DATA_W-1:0] rsp_data;

  // array ports
  line_state_e       arr_state;
  logic [ADDR_W-1:0] arr_addr;
  logic [DATA_W-1:0] arr_data;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  line_state_e       wr_state;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;

  // lookup result
  logic              lk_hit;
  line_state_e       lk_state;
  logic [ADDR_W-1:0] lk_addr;
  logic [DATA_W-1:0] lk_data;

  // stage two control
  logic mreq_valid, mreq_wb, s2_done, fill_start, wb_fire, rsp_load, s2_we;
  logic rsp_free, s1_adv, fill_fire, req_fire;

  // line written back by stage two
  line_state_e       post_state;
  logic [ADDR_W-1:0] post_addr;
  logic [DATA_W-1:0] post_data;

  assign rsp_free  = !rsp_v || cpu_rsp_ready;
  assign fill_fire = mem_rsp_valid && mem_rsp_ready;
  assign req_fire  = cpu_req_valid && cpu_req_ready;

  // stage two frees up unless it is launching a fill; nothing moves during a fill
  assign s1_adv = s1_v && !fill_wait && (!s2_v || (s2_done && !fill_start));

  assign cpu_req_ready = !fill_wait && !rsp_fill && (!s1_v || s1_adv);
  assign mem_rsp_ready = fill_wait && rsp_free;

  wbc_line_store #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lines (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_state (wr_state),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rd_idx   (s1_addr[IDX_W-1:0]),
    .rd_state (arr_state),
    .rd_addr  (arr_addr),
    .rd_data  (arr_data)
  );

  wbc_lookup #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_lookup (
    .req_addr  (s1_addr),
    .arr_state (arr_state),
    .arr_addr  (arr_addr),
    .arr_data  (arr_data),
    .fwd_en    (s2_we),
    .fwd_idx   (s2_addr[IDX_W-1:0]),
    .fwd_state (post_state),
    .fwd_addr  (post_addr),
    .fwd_data  (post_data),
    .hit       (lk_hit),
    .vic_state (lk_state),
    .vic_addr  (lk_addr),
    .vic_data  (lk_data)
  );

  wbc_stage2_ctrl u_s2ctl (
    .clk          (clk),
    .rst_n        (rst_n),
    .s2_valid     (s2_v),
    .s2_store     (s2_store),
    .s2_hit       (s2_hit),
    .s2_vic_state (s2_vstate),
    .s2_wb_done   (s2_wb_done),
    .mreq_ready   (mem_req_ready),
    .rsp_free     (rsp_free),
    .mreq_valid   (mreq_valid),
    .mreq_wb      (mreq_wb),
    .done         (s2_done),
    .fill_start   (fill_start),
    .wb_fire      (wb_fire),
    .rsp_load     (rsp_load),
    .line_we      (s2_we)
  );

  // store installs a dirty line, a load miss leaves the line invalid until filled
  always_comb begin
    if (s2_store) begin
      post_state = LS_DIRTY;
      post_addr  = s2_addr;
      post_data  = s2_data;
    end else begin
      post_state = LS_INVALID;
      post_addr  = s2_vaddr;
      post_data  = s2_vdata;
    end
  end

  // stage two and fills never write in the same cycle (stage two is empty during a fill)
  always_comb begin
    wr_en = s2_we || fill_fire;
    if (fill_fire) begin
      wr_idx   = mem_rsp_idx;
      wr_state = LS_CLEAN;
      wr_addr  = mem_rsp_addr;
      wr_data  = mem_rsp_rdata;
    end else begin
      wr_idx   = s2_addr[IDX_W-1:0];
      wr_state = post_state;
      wr_addr  = post_addr;
      wr_data  = post_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_store <= 1'b0;
      s1_addr  <= '0;
      s1_data  <= '0;
    end else if (req_fire) begin
      s1_v     <= 1'b1;
      s1_store <= cpu_req_store;
      s1_addr  <= cpu_req_addr;
      s1_data  <= cpu_req_wdata;
    end else if (s1_adv) begin
      s1_v <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s2_v       <= 1'b0;
      s2_store   <= 1'b0;
      s2_addr    <= '0;
      s2_data    <= '0;
      s2_hit     <= 1'b0;
      s2_vstate  <= LS_INVALID;
      s2_vaddr   <= '0;
      s2_vdata   <= '0;
      s2_wb_done <= 1'b0;
    end else if (s1_adv) begin
      s2_v       <= 1'b1;
      s2_store   <= s1_store;
      s2_addr    <= s1_addr;
      s2_data    <= s1_data;
      s2_hit     <= lk_hit;
      s2_vstate  <= lk_state;
      s2_vaddr   <= lk_addr;
      s2_vdata   <= lk_data;
      s2_wb_done <= 1'b0;
    end else if (s2_done) begin
      s2_v       <= 1'b0;
    end else if (wb_fire) begin
      s2_wb_done <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_wait <= 1'b0;
    end else if (fill_start) begin
      fill_wait <= 1'b1;
    end else if (fill_fire) begin
      fill_wait <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v    <= 1'b0;
      rsp_fill <= 1'b0;
      rsp_data <= '0;
    end else if (rsp_load) begin
      rsp_v    <= 1'b1;
      rsp_fill <= 1'b0;
      rsp_data <= s2_vdata;
    end else if (fill_fire) begin
      rsp_v    <= 1'b1;
      rsp_fill <= 1'b1;
      rsp_data <= mem_rsp_rdata;
    end else if (cpu_rsp_ready) begin
      rsp_v    <= 1'b0;
      rsp_fill <= 1'b0;
    end
  end

  assign cpu_rsp_valid     = rsp_v;
  assign cpu_rsp_rdata     = rsp_data;
  assign mem_req_valid     = mreq_valid;
  assign mem_req_writeback = mreq_wb;
  assign mem_req_idx       = s2_addr[IDX_W-1:0];
  assign mem_req_addr      = mreq_wb ? s2_vaddr : s2_addr;
  assign mem_req_wdata     = mreq_wb ? s2_vdata : '0;

  AST_MREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_writeback)
      && $stable(mem_req_addr) && $stable(mem_req_wdata) && $stable(mem_req_idx))); // R11

  AST_CRSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rsp_valid && !cpu_rsp_ready) |=> (cpu_rsp_valid && $stable(cpu_rsp_rdata))); // R11

  AST_FETCH_BLOCKS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && !mem_req_writeback) |=> !cpu_req_ready); // R6

  AST_SINGLE_MISS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_wait |-> !mem_req_valid); // R6

  AST_FILL_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rsp_valid && mem_rsp_ready) |=> (cpu_rsp_valid && cpu_rsp_rdata == $past(mem_rsp_rdata))); // R9
endmodule

// File: tb/wb_cache_ctrl_test.sv
`timescale 1ns/1ps
module wb_cache_ctrl_test;
  localparam int LINES  = 4;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req_valid = 1'b0;
  logic              cpu_req_ready;
  logic              cpu_req_store = 1'b0;
  logic [ADDR_W-1:0] cpu_req_addr = '0;
  logic [DATA_W-1:0] cpu_req_wdata = '0;
  logic              cpu_rsp_valid;
  logic              cpu_rsp_ready = 1'b1;
  logic [DATA_W-1:0] cpu_rsp_rdata;
  logic              mem_req_valid;
  logic              mem_req_ready = 1'b1;
  logic              mem_req_writeback;
  logic [IDX_W-1:0]  mem_req_idx;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [DATA_W-1:0] mem_req_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic              mem_rsp_ready;
  logic [IDX_W-1:0]  mem_rsp_idx = '0;
  logic [ADDR_W-1:0] mem_rsp_addr = '0;
  logic [DATA_W-1:0] mem_rsp_rdata = '0;

  always #2 clk = ~clk;

  wb_cache_ctrl #(.LINES(LINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) uut (.*);

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  // observations of one window
  int wb_cnt, get_cnt, rsp_cnt, rsp_lat;
  logic [ADDR_W-1:0] wb_addr, get_addr;
  logic [DATA_W-1:0] wb_data, rsp_dat;
  logic [IDX_W-1:0]  get_idx;
  logic              rdy_in_fill;

  function automatic logic [DATA_W-1:0] fill_word(input logic [ADDR_W-1:0] a);
    return {a, a ^ 16'hBEEF};
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic issue(input logic st, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bit acc = 1'b0;
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_store = st; cpu_req_addr = a; cpu_req_wdata = d;
    while (!acc) begin
      #1 acc = cpu_req_ready;
      @(posedge clk);
      if (!acc) @(negedge clk);
    end
  endtask

  task automatic watch(input int n);
    bit acc_prev = 1'b0;
    bit get_pend = 1'b0;
    bit rdy_next = 1'b0;
    logic [IDX_W-1:0]  pi = '0;
    logic [ADDR_W-1:0] pa = '0;
    wb_cnt = 0; get_cnt = 0; rsp_cnt = 0; rsp_lat = 0; rdy_in_fill = 1'b1;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      cpu_req_valid = 1'b0;
      if (mem_rsp_valid && acc_prev) mem_rsp_valid = 1'b0;
      if (get_pend) begin
        mem_rsp_valid = 1'b1; mem_rsp_idx = pi; mem_rsp_addr = pa;
        mem_rsp_rdata = fill_word(pa); get_pend = 1'b0;
      end
      #1;
      acc_prev = mem_rsp_valid && mem_rsp_ready;
      if (rdy_next) begin rdy_in_fill = cpu_req_ready; rdy_next = 1'b0; end
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_writeback) begin
          wb_cnt++; wb_addr = mem_req_addr; wb_data = mem_req_wdata;
        end else begin
          get_cnt++; get_addr = mem_req_addr; get_idx = mem_req_idx;
          pi = mem_req_idx; pa = mem_req_addr; get_pend = 1'b1; rdy_next = 1'b1;
        end
      end
      if (cpu_rsp_valid && cpu_rsp_ready) begin
        rsp_cnt++; rsp_dat = cpu_rsp_rdata;
        if (rsp_lat == 0) rsp_lat = k;
      end
    end
  endtask

  typedef struct packed {
    logic              st;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] d;
    logic              rsp;
    logic              rfill;
    logic [DATA_W-1:0] rd;
    logic              wb;
    logic [ADDR_W-1:0] wa;
    logic [DATA_W-1:0] wd;
    logic              get;
    logic [3:0]        rq;
  } vec_t;

  localparam vec_t VEC [14] = '{
    '{1'b0, 16'h0010, 32'h0,        1'b1, 1'b1, 32'h0,        1'b0, 16'h0,    32'h0,        1'b1, 4'd6}, // R6 miss on invalid
    '{1'b0, 16'h0010, 32'h0,        1'b1, 1'b1, 32'h0,        1'b0, 16'h0,    32'h0,        1'b0, 4'd9}, // R9 filled line hits
    '{1'b1, 16'h0010, 32'h11111111, 1'b0, 1'b0, 32'h0,        1'b0, 16'h0,    32'h0,        1'b0, 4'd2}, // R2 store hit
    '{1'b0, 16'h0010, 32'h0,        1'b1, 1'b0, 32'h11111111, 1'b0, 16'h0,    32'h0,        1'b0, 4'd2}, // R2 readback
    '{1'b1, 16'h0020, 32'h22222222, 1'b0, 1'b0, 32'h0,        1'b1, 16'h0010, 32'h11111111, 1'b0, 4'd5}, // R5 dirty victim
    '{1'b0, 16'h0020, 32'h0,        1'b1, 1'b0, 32'h22222222, 1'b0, 16'h0,    32'h0,        1'b0, 4'd5}, // R5 new line
    '{1'b1, 16'h0005, 32'h33333333, 1'b0, 1'b0, 32'h0,        1'b0, 16'h0,    32'h0,        1'b0, 4'd4}, // R4 store to invalid
    '{1'b0, 16'h0005, 32'h0,        1'b1, 1'b0, 32'h33333333, 1'b0, 16'h0,    32'h0,        1'b0, 4'd4}, // R4 readback
    '{1'b0, 16'h0105, 32'h0,        1'b1, 1'b1, 32'h0,        1'b1, 16'h0005, 32'h33333333, 1'b1, 4'd7}, // R7 load on dirty
    '{1'b0, 16'h0205, 32'h0,        1'b1, 1'b1, 32'h0,        1'b0, 16'h0,    32'h0,        1'b1, 4'd8}, // R8 load on clean
    '{1'b1, 16'h0305, 32'h44444444, 1'b0, 1'b0, 32'h0,        1'b0, 16'h0,    32'h0,        1'b0, 4'd4}, // R4 store on clean
    '{1'b0, 16'h0305, 32'h0,        1'b1, 1'b0, 32'h44444444, 1'b0, 16'h0,    32'h0,        1'b0, 4'd3}, // R3 load hit
    '{1'b0, 16'h0002, 32'h0,        1'b1, 1'b1, 32'h0,        1'b0, 16'h0,    32'h0,        1'b1, 4'd6}, // R6 second index
    '{1'b1, 16'h0006, 32'h55555555, 1'b0, 1'b0, 32'h0,        1'b0, 16'h0,    32'h0,        1'b0, 4'd9}  // R9 clean victim, no write-back
  };

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    string rq;
    logic [DATA_W-1:0] exp_d;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(cpu_req_ready == 1'b1, "R1", "req_ready", 64'(cpu_req_ready), 64'd1);
    chk(cpu_rsp_valid == 1'b0, "R1", "rsp_valid", 64'(cpu_rsp_valid), 64'd0);
    chk(mem_req_valid == 1'b0, "R1", "mem_req_valid", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;

    // table walk
    foreach (VEC[i]) begin
      rq = $sformatf("R%0d row%0d", VEC[i].rq, i);
      issue(VEC[i].st, VEC[i].a, VEC[i].d);
      watch(14);
      chk(wb_cnt == int'(VEC[i].wb), rq, "writeback count", 64'(wb_cnt), 64'(VEC[i].wb));
      if (VEC[i].wb && wb_cnt == 1) begin
        chk(wb_addr == VEC[i].wa, rq, "writeback addr", 64'(wb_addr), 64'(VEC[i].wa));
        chk(wb_data == VEC[i].wd, rq, "writeback data", 64'(wb_data), 64'(VEC[i].wd));
      end
      chk(get_cnt == int'(VEC[i].get), rq, "fetch count", 64'(get_cnt), 64'(VEC[i].get));
      if (VEC[i].get && get_cnt == 1) begin
        chk(get_addr == VEC[i].a, rq, "fetch addr", 64'(get_addr), 64'(VEC[i].a));
        chk(get_idx == VEC[i].a[IDX_W-1:0], rq, "fetch idx", 64'(get_idx), 64'(VEC[i].a[IDX_W-1:0]));
        chk(rdy_in_fill == 1'b0, rq, "req_ready during fill", 64'(rdy_in_fill), 64'd0);
      end
      chk(rsp_cnt == int'(VEC[i].rsp), rq, "response count", 64'(rsp_cnt), 64'(VEC[i].rsp));
      if (VEC[i].rsp && rsp_cnt == 1) begin
        exp_d = VEC[i].rfill ? fill_word(VEC[i].a) : VEC[i].rd;
        chk(rsp_dat == exp_d, rq, "response data", 64'(rsp_dat), 64'(exp_d));
        if (!VEC[i].get)
          chk(rsp_lat == 3, rq, "hit latency (R3)", 64'(rsp_lat), 64'd3);
      end
    end

    // R10: back-to-back stores to one index on consecutive cycles
    begin
      logic r_a, r_b;
      @(negedge clk);
      cpu_req_valid = 1'b1; cpu_req_store = 1'b1; cpu_req_addr = 16'h0003; cpu_req_wdata = 32'hAAAA0003;
      #1 r_a = cpu_req_ready;
      @(negedge clk);
      cpu_req_addr = 16'h0103; cpu_req_wdata = 32'hBBBB0103;
      #1 r_b = cpu_req_ready;
      chk(r_a && r_b, "R10", "ready on both cycles", 64'({r_a, r_b}), 64'h3);
      @(posedge clk);
      watch(12);
      chk(wb_cnt == 1, "R10", "writeback count", 64'(wb_cnt), 64'd1);
      chk(wb_addr == 16'h0003 && wb_data == 32'hAAAA0003, "R10", "writeback payload",
          {16'h0, wb_addr, wb_data}, {16'h0, 16'h0003, 32'hAAAA0003});
      issue(1'b0, 16'h0103, '0);
      watch(10);
      chk(rsp_cnt == 1 && rsp_dat == 32'hBBBB0103, "R10", "second store data",
          64'(rsp_dat), 64'h00000000BBBB0103);
    end

    // R11: write-back held under memory back-pressure
    begin
      bit held = 1'b1;
      mem_req_ready = 1'b0;
      issue(1'b1, 16'h0106, 32'h66660106);
      @(negedge clk); cpu_req_valid = 1'b0;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk); #1;
        if (!(mem_req_valid && mem_req_writeback && mem_req_addr == 16'h0006
              && mem_req_wdata == 32'h55555555)) held = 1'b0;
      end
      chk(held, "R11", "write-back held steady", 64'(held), 64'd1);
      chk(cpu_req_ready == 1'b1, "R11", "stage one free", 64'(cpu_req_ready), 64'd1);
      mem_req_ready = 1'b1;
      @(negedge clk); #1;
      chk(mem_req_valid == 1'b0, "R11", "released after take", 64'(mem_req_valid), 64'd0);
      issue(1'b0, 16'h0106, '0);
      watch(10);
      chk(rsp_cnt == 1 && rsp_dat == 32'h66660106, "R11", "line replaced after take",
          64'(rsp_dat), 64'h0000000066660106);
      chk(wb_cnt == 0 && get_cnt == 0, "R11", "no extra traffic", 64'(wb_cnt + get_cnt), 64'd0);
    end

    finish_run();
  end
endmodule